// File: doc/BRIEF.md
# Bidirectional Port with Per-Bit Readback

This block is one general-purpose I/O port of a microcontroller-style chip. It holds a data latch and a direction register, each as wide as the port. It drives the pad output and output-enable lines, and it exports per-bit pull-up enables. A pad whose direction bit is 1 is an input. A pad whose direction bit is 0 drives its latch bit.

Software uses a small register bus with plain control pins. The data register and the direction register sit at adjacent addresses. A write can load a whole byte, or it can set or clear one bit and leave the others alone. A read of the data address is assembled bit by bit. Input-mode bits return the synchronized pad level. Output-mode bits return the latch. Because output bits read back their own latch, a read-modify-write sequence keeps output values intact.

One parameter-chosen pin can carry a divider clock in place of its latch value. That clock is gated by the pin's own latch bit. Any pin in input mode can raise a sticky wake-up request. The request is raised when the pin's synchronized level differs from the level captured the last time the request was acknowledged.

Top module: `bidir_port`

## Requirements
- R1: For every bit, `pad_oe` is 1 exactly when the direction bit is 0. An output-mode bit drives its data latch bit on `pad_out`.
- R2: A read at `ADDR_DATA` returns, for each bit, the pad level when the direction bit is 1 and the latch bit when it is 0. The pad level passes through two flops, so a pad change shows in the read after the second rising edge.
- R3: The data latch changes only on a bus write to `ADDR_DATA` with op 0, 1 or 2. Writes to other addresses, op 3, or `bus_we` low leave it unchanged.
- R4: After reset the direction register is all 1s, so every `pad_oe` bit is 0. The data latch is all 1s and `wake_req` is 0.
- R5: The `bus_op` encoding is 0 for a full write of `bus_wdata`, 1 to set bit `bus_bit`, 2 to clear bit `bus_bit`, and 3 for no change. The encoding applies to both registers. A set or clear alters only the addressed bit.
- R6: When `alt_sel` is 1, pin `ALT_BIT` outputs `alt_div AND latch[ALT_BIT]`. When `alt_sel` is 0 it outputs its latch bit. Other pins are never affected.
- R7: `pull_en[i]` equals `pull_cfg AND direction[i]`, so a pull-up is never enabled on a driven bit.
- R8: `wake_req` rises on the third rising edge after an input-mode pad changes away from its snapshot level. A change on an output-mode pad never raises it.
- R9: `wake_req` stays 1 until `wake_ack`. The edge that samples `wake_ack` clears the request and reloads the snapshot from the synchronized pads.
- R10: A read at `ADDR_DATA+1` returns the direction register. Any other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_op | input | 2 | 0 full write, 1 set bit, 2 clear bit, 3 no change |
| bus_bit | input | BW | Bit index for set and clear |
| bus_wdata | input | W | Write data for a full write |
| bus_rdata | output | W | Combinational read data |
| pad_in | input | W | Pad input levels, asynchronous |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables, 1 drives |
| pull_cfg | input | 1 | Static pull-up option for the port |
| pull_en | output | W | Per-bit pull-up enable |
| alt_sel | input | 1 | Static option routing the divider to pin ALT_BIT |
| alt_div | input | 1 | Divider clock for the alternate pin |
| wake_ack | input | 1 | Clears the wake request and re-snapshots the pads |
| wake_req | output | 1 | Sticky wake-up request |

## Verification
The bench builds the port with W=8 and AW=4, like the defaults. It moves `ALT_BIT` to 5 and `ADDR_DATA` to 6. This shows that the alternate pin and the register pair follow their parameters and are not fixed positions. With the direction register at 7, the bench can also show that addresses 0 and 5 read as zero. It can mix input and output bits in one byte, so a single read shows both sources. It can toggle an output-mode pad to show that it is ignored for wake-up.

// File: rtl/port_pkg.sv
package port_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } port_op_e;
endpackage

// File: rtl/port_sync.sv
module port_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  // Two flops per bit; each bit is an independent synchronizer.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_in[i];
        s2_q <= s1_q;
      end
    end
    assign sync_out[i] = s2_q;
  end
endmodule

// File: rtl/port_regs.sv
module port_regs
  import port_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          AW        = 4,
  parameter int          BW        = 3,
  parameter logic [AW-1:0] ADDR_DATA = '0,
  parameter logic [W-1:0]  DATA_RST  = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [1:0]    bus_op,
  input  logic [BW-1:0] bus_bit,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  dir_q
);
  localparam logic [AW-1:0] ADDR_CTRL = ADDR_DATA + AW'(1);

  logic          hit_data, hit_ctrl;
  logic [W-1:0]  bit_mask;
  logic [W-1:0]  data_nx, dir_nx;

  assign hit_data = bus_we && (bus_addr == ADDR_DATA);
  assign hit_ctrl = bus_we && (bus_addr == ADDR_CTRL);
  assign bit_mask = W'(1) << bus_bit;

  function automatic logic [W-1:0] apply_op(input logic [W-1:0] cur,
                                            input logic [1:0] op,
                                            input logic [W-1:0] mask,
                                            input logic [W-1:0] wd);
    case (port_op_e'(op))
      OP_WRITE: apply_op = wd;
      OP_SET:   apply_op = cur | mask;
      OP_CLR:   apply_op = cur & ~mask;
      default:  apply_op = cur;
    endcase
  endfunction

  assign data_nx = apply_op(data_q, bus_op, bit_mask, bus_wdata);
  assign dir_nx  = apply_op(dir_q,  bus_op, bit_mask, bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_RST;
      dir_q  <= '1;
    end else begin
      if (hit_data) data_q <= data_nx;
      if (hit_ctrl) dir_q  <= dir_nx;
    end
  end

  // Latch keeps its value when not addressed (R3)
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_data |=> $stable(data_q));

  // Set op forces the addressed bit to 1 (R5)
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && bus_op == 2'd1) |=> data_q[$past(bus_bit)]);

  // Clear op forces the addressed bit to 0 (R5)
  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && bus_op == 2'd2) |=> !data_q[$past(bus_bit)]);

  // Single-bit ops touch at most one bit (R5)
  p_onebit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && (bus_op == 2'd1 || bus_op == 2'd2))
      |=> $countones(data_q ^ $past(data_q)) <= 1);
endmodule

// File: rtl/port_wake.sv
module port_wake #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] in_mode,
  input  logic         wake_ack,
  output logic         wake_req
);
  logic [W-1:0] snap_q;
  logic [W-1:0] moved;

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign moved[i] = in_mode[i] & (pin_sync[i] ^ snap_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      wake_req <= 1'b0;
    end else if (wake_ack) begin
      snap_q   <= pin_sync;
      wake_req <= 1'b0;
    end else if (|moved) begin
      wake_req <= 1'b1;
    end
  end

  // Acknowledge clears the request (R9)
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |=> !wake_req);

  // Request is sticky until acknowledged (R9)
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_ack) |=> wake_req);

  // Output-mode pins alone never raise a request (R8)
  p_outonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_req && !wake_ack && in_mode == '0) |=> !wake_req);
endmodule

// File: rtl/port_altmux.sv
module port_altmux #(
  parameter int W       = 8,
  parameter int ALT_BIT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] latch,
  input  logic         alt_sel,
  input  logic         alt_div,
  output logic [W-1:0] pin_val
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i == ALT_BIT) begin : g_alt
      assign pin_val[i] = alt_sel ? (alt_div & latch[i]) : latch[i];
    end else begin : g_std
      assign pin_val[i] = latch[i];
    end
  end

  // Divider is gated off by a cleared latch bit (R6)
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_sel && !latch[ALT_BIT]) |-> !pin_val[ALT_BIT]);
endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import port_pkg::*;
#(
  parameter int            W         = 8,
  parameter int            AW        = 4,
  parameter int            ALT_BIT   = 3,
  parameter logic [AW-1:0] ADDR_DATA = 4'd2,
  parameter logic [W-1:0]  DATA_RST  = '1,
  localparam int           BW        = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [1:0]    bus_op,
  input  logic [BW-1:0] bus_bit,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic          pull_cfg,
  output logic [W-1:0]  pull_en,
  input  logic          alt_sel,
  input  logic          alt_div,
  input  logic          wake_ack,
  output logic          wake_req
);
  localparam logic [AW-1:0] ADDR_CTRL = ADDR_DATA + AW'(1);

  logic [W-1:0] data_q, dir_q, pin_sync, data_view;

  port_regs #(.W(W), .AW(AW), .BW(BW), .ADDR_DATA(ADDR_DATA), .DATA_RST(DATA_RST)) u_regs (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_op, .bus_bit, .bus_wdata,
    .data_q, .dir_q
  );

  port_sync #(.W(W)) u_sync (
    .clk, .rst_n, .async_in(pad_in), .sync_out(pin_sync)
  );

  port_wake #(.W(W)) u_wake (
    .clk, .rst_n, .pin_sync, .in_mode(dir_q), .wake_ack, .wake_req
  );

  port_altmux #(.W(W), .ALT_BIT(ALT_BIT)) u_alt (
    .clk, .rst_n, .latch(data_q), .alt_sel, .alt_div, .pin_val(pad_out)
  );

  assign pad_oe  = ~dir_q;
  assign pull_en = {W{pull_cfg}} & dir_q;

  for (genvar i = 0; i < W; i++) begin : g_view
    assign data_view[i] = dir_q[i] ? pin_sync[i] : data_q[i];
  end

  always_comb begin
    if (bus_addr == ADDR_DATA)      bus_rdata = data_view;
    else if (bus_addr == ADDR_CTRL) bus_rdata = dir_q;
    else                            bus_rdata = '0;
  end

  // Pull-up never enabled on a driven pin (R7)
  p_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & pad_oe) == '0);

  // Output-mode bits read back their driven latch value (R2)
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_DATA) |-> ((bus_rdata & pad_oe) == (data_q & pad_oe)));
endmodule

// File: tb/bidir_port_test.sv
module bidir_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int AW = 4;
  localparam int ALT = 5;
  localparam logic [AW-1:0] AD = 4'd6;
  localparam logic [AW-1:0] AC = 4'd7;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 0;
  logic [1:0]    bus_op = '0;
  logic [2:0]    bus_bit = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pad_in = '0;
  logic [W-1:0]  pad_out, pad_oe, pull_en;
  logic          pull_cfg = 0, alt_sel = 0, alt_div = 0, wake_ack = 0;
  logic          wake_req;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_port #(.W(W), .AW(AW), .ALT_BIT(ALT), .ADDR_DATA(AD)) uut (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_op, .bus_bit, .bus_wdata, .bus_rdata,
    .pad_in, .pad_out, .pad_oe, .pull_cfg, .pull_en, .alt_sel, .alt_div,
    .wake_ack, .wake_req
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_access(input logic [AW-1:0] a, input logic [1:0] op,
                            input logic [2:0] b, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_op = op; bus_bit = b; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic read_at(input logic [AW-1:0] a, output logic [W-1:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    chk("R4 oe", pad_oe, 0);
    chk("R4 wake", wake_req, 0);
    read_at(AC, v); chk("R4 dir", v, 8'hFF);
    chk("R4 latch", pad_out, 8'hFF);
    read_at(4'd0, v); chk("R10 unmapped lo", v, 0);
    read_at(4'd5, v); chk("R10 unmapped 5", v, 0);
  endtask

  task automatic t_dir_out;
    bus_access(AD, 2'd0, 0, 8'hA5);
    bus_access(AC, 2'd0, 0, 8'h0F);
    chk("R1 oe", pad_oe, 8'hF0);
    chk("R1 out", pad_out & pad_oe, 8'hA0);
  endtask

  task automatic t_readmix;
    logic [W-1:0] v;
    @(negedge clk); pad_in = 8'h3C;
    read_at(AD, v); chk("R2 before sync", v, 8'hA0);
    @(negedge clk); read_at(AD, v); chk("R2 one flop", v, 8'hA0);
    @(negedge clk); read_at(AD, v); chk("R2 mixed", v, 8'hAC);
    read_at(AC, v); chk("R10 dir read", v, 8'h0F);
  endtask

  task automatic t_bitops;
    bus_access(AC, 2'd0, 0, 8'h00);
    bus_access(AD, 2'd0, 0, 8'h81);
    bus_access(AD, 2'd1, 3, 0);
    chk("R5 set", pad_out, 8'h89);
    bus_access(AD, 2'd2, 7, 8'hFF);
    chk("R5 clr", pad_out, 8'h09);
    bus_access(AD, 2'd3, 0, 8'h55);
    chk("R3 op3 ignored", pad_out, 8'h09);
    bus_access(4'd2, 2'd0, 0, 8'h55);
    chk("R3 other addr", pad_out, 8'h09);
    bus_access(AC, 2'd1, 1, 0);
    chk("R5 ctrl set", pad_oe, 8'hFD);
  endtask

  task automatic t_alt;
    bus_access(AC, 2'd0, 0, 8'h00);
    bus_access(AD, 2'd0, 0, 8'hFF);
    @(negedge clk); alt_sel = 1; alt_div = 0; #1;
    chk("R6 div low", pad_out, 8'hDF);
    alt_div = 1; #1;
    chk("R6 div high", pad_out, 8'hFF);
    bus_access(AD, 2'd2, 5, 0);
    chk("R6 gated", pad_out[ALT], 0);
    alt_sel = 0; alt_div = 0;
  endtask

  task automatic t_pull;
    bus_access(AC, 2'd0, 0, 8'hC3);
    pull_cfg = 0; #1; chk("R7 off", pull_en, 0);
    pull_cfg = 1; #1; chk("R7 on", pull_en, 8'hC3);
    pull_cfg = 0;
  endtask

  task automatic t_wake;
    bus_access(AC, 2'd0, 0, 8'h0F);
    @(negedge clk); wake_ack = 1; @(negedge clk); wake_ack = 0;
    chk("R9 ack clear", wake_req, 0);
    pad_in = pad_in ^ 8'hF0;
    repeat (4) @(negedge clk);
    chk("R8 output pin ignored", wake_req, 0);
    pad_in = pad_in ^ 8'h02;
    @(negedge clk); @(negedge clk);
    chk("R8 not yet", wake_req, 0);
    @(negedge clk);
    chk("R8 raised", wake_req, 1);
    pad_in = pad_in ^ 8'h02;
    repeat (3) @(negedge clk);
    chk("R9 sticky", wake_req, 1);
    wake_ack = 1; @(negedge clk); wake_ack = 0;
    chk("R9 cleared", wake_req, 0);
    @(negedge clk);
    chk("R9 resnap", wake_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_dir_out;
    t_readmix;
    t_bitops;
    t_alt;
    t_pull;
    t_wake;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule